// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes stereo PCM from a three-wire serial audio link (bit clock, word clock, serial data) and turns it into a parallel pair of 24-bit samples, left and right, handed over on a valid/ready output. All link lines are brought into the system clock domain through synchronizers. A rising edge of the chosen bit clock becomes a one-cycle sampling event. On each event the word-clock level and the data bit are taken together.

Three framings are decoded: I2S, left-justified and right-justified. The bit clock can come from three sources. The first is the dedicated bit-clock pin. The second is an internal divider running from the master clock; in that mode the bit-clock pin is a strap that picks 16 or 32 bit clocks per channel. The third is the master clock itself. In every case the bit clock must be synchronous with the master clock and must run at the rate of the incoming data.

The output has no storage beyond one pair. The serial source cannot be stalled, so back-pressure never reaches the link. While `out_ready_i` is low, the pending pair is held. If a newer pair completes before it is taken, the newer pair replaces it. With `out_ready_i` held high, `out_valid_o` is a one-cycle strobe per frame.

Top module: `audrx_top`

## Requirements
- R1: After reset `out_valid_o` is low and both sample outputs are zero. The first pair is delivered only for the first frame that starts after the first word-clock transition seen since reset, so a stream of frames 0..F closed by one extra transition yields exactly F pairs (frames 1..F).
- R2: With `fmt_sel_i` = 0 (I2S), a low word clock marks the left channel and a high one marks the right. The MSB arrives one bit clock after the word-clock change. A word covers the slots from there up to and including the slot in which the word clock next changes.
- R3: With `fmt_sel_i` = 1 (left-justified), a high word clock marks the left channel. The MSB is in the same slot as the word-clock change.
- R4: With `fmt_sel_i` = 2 (right-justified), a high word clock marks the left channel. The last bit before the next word-clock change is the LSB, and the word length equals the number of bit clocks in that channel.
- R5: Samples leave MSB-aligned in 24 bits. A shorter word is padded with zeros below its LSB. For a longer word, I2S and left-justified keep its first 24 bits and right-justified keeps its last 24 bits.
- R6: With `bclk_src_i` = 0, each rising edge of `bclk_i` samples `wclk_i` and `sdata_i`.
- R7: With `bclk_src_i` = 1, a bit-clock event occurs on every MCLK_PER_FS/(2·n)-th rising edge of `mclk_i`, counted from reset. Here n is 16 when `bclk_i` is high and 32 when it is low (8 and 4 master clocks per bit at the default of 256).
- R8: With `bclk_src_i` = 2, rising edges of `mclk_i` serve as the bit clock, and activity on `bclk_i` has no effect on the delivered samples.
- R9: When a right word completes after its left word, the pair is presented with `out_valid_o`. With `out_ready_i` high, `out_valid_o` stays high for exactly one clock.
- R10: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and the sample outputs stay stable until a newer pair arrives.
- R11: A pair that completes while an earlier one is still unaccepted replaces it; the output then shows the newest pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| fmt_sel_i | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 treated as I2S |
| bclk_src_i | input | 2 | Bit-clock source: 0 pin, 1 divided master clock, 2 master clock, 3 treated as pin |
| mclk_i | input | 1 | Master clock line |
| bclk_i | input | 1 | Bit-clock pin; rate strap when the divider is the source |
| wclk_i | input | 1 | Word clock |
| sdata_i | input | 1 | Serial data |
| out_ready_i | input | 1 | Consumer ready |
| out_valid_o | output | 1 | Sample pair valid |
| out_left_o | output | 24 | Left sample, MSB-aligned |
| out_right_o | output | 24 | Right sample, MSB-aligned |

## Verification
The assertions check, on every cycle, the properties of the output handshake: a single-cycle beat when the consumer is ready, and a held, stable pair under back-pressure. They also check that bit-clock events are never adjacent and that no pair is produced before a word-clock transition has been seen. Bit placement cannot be shown by a per-cycle property, so the bench scenarios cover it. They cover all three framings at 16, 24 and 32 bits per channel, the divider at both strap settings, the master-clock source with a toggling bit-clock pin, and replacement of an unaccepted pair by a newer one.

// File: rtl/audrx_pkg.sv
package audrx_pkg;

  typedef enum logic [1:0] {
    FMT_I2S    = 2'd0,
    FMT_LEFTJ  = 2'd1,
    FMT_RIGHTJ = 2'd2,
    FMT_RSVD   = 2'd3
  } fmt_e;

  typedef enum logic [1:0] {
    SRC_PIN     = 2'd0,
    SRC_DIVIDED = 2'd1,
    SRC_MASTER  = 2'd2,
    SRC_RSVD    = 2'd3
  } bsrc_e;

  localparam int unsigned SLOTS_SHORT = 16;
  localparam int unsigned SLOTS_LONG  = 32;

endpackage

// File: rtl/audrx_sync.sv
module audrx_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/audrx_bitclk.sv
module audrx_bitclk
  import audrx_pkg::*;
#(
  parameter int unsigned MCLK_PER_FS = 256
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  bsrc_e src_i,
  input  logic  mclk_lvl_i,
  input  logic  pin_lvl_i,
  output logic  bit_evt_o
);

  localparam int unsigned DIV_SHORT = MCLK_PER_FS / (2 * SLOTS_SHORT);
  localparam int unsigned DIV_LONG  = MCLK_PER_FS / (2 * SLOTS_LONG);
  localparam int unsigned DIV_W     = $clog2(DIV_SHORT) + 1;

  logic             mclk_d_q, pin_d_q;
  logic             mclk_rise, pin_rise;
  logic [DIV_W-1:0] div_cnt_q;
  logic [DIV_W-1:0] div_last;
  logic             div_hit;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      mclk_d_q <= 1'b0;
      pin_d_q  <= 1'b0;
    end else begin
      mclk_d_q <= mclk_lvl_i;
      pin_d_q  <= pin_lvl_i;
    end
  end

  assign mclk_rise = mclk_lvl_i & ~mclk_d_q;
  assign pin_rise  = pin_lvl_i & ~pin_d_q;

  // Strap level picks the division: high gives the shorter frame, hence the larger divide.
  assign div_last = pin_lvl_i ? DIV_W'(DIV_SHORT - 1) : DIV_W'(DIV_LONG - 1);
  assign div_hit  = mclk_rise && (div_cnt_q >= div_last);

  always_ff @(posedge clk_i) begin
    if (!rst_ni || (src_i != SRC_DIVIDED)) begin
      div_cnt_q <= '0;
    end else if (mclk_rise) begin
      div_cnt_q <= div_hit ? '0 : div_cnt_q + 1'b1;
    end
  end

  always_comb begin
    unique case (src_i)
      SRC_DIVIDED: bit_evt_o = div_hit;
      SRC_MASTER:  bit_evt_o = mclk_rise;
      default:     bit_evt_o = pin_rise;
    endcase
  end

  AST_EVT_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_evt_o |=> !bit_evt_o); // R6

endmodule

// File: rtl/audrx_frame.sv
module audrx_frame
  import audrx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned CNT_W    = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  fmt_e                fmt_i,
  input  logic                bit_evt_i,
  input  logic                wclk_i,
  input  logic                sdata_i,
  output logic                pair_o,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                primed_q, started_q, prev_w_q, left_ok_q, pair_q;
  logic [SAMPLE_W-1:0] acc_q, left_q, right_q;
  logic [CNT_W-1:0]    cnt_q;

  logic                is_i2s, is_rj, edge_w, fin_is_left;
  logic [SAMPLE_W-1:0] msb_acc, shift_acc, next_acc, rj_fin, fin_word, start_acc;
  logic [CNT_W-1:0]    cnt_inc, start_cnt;

  function automatic logic [SAMPLE_W-1:0] put_msb(input logic [SAMPLE_W-1:0] a,
                                                  input logic [CNT_W-1:0]    idx,
                                                  input logic                b);
    logic [SAMPLE_W-1:0] r;
    r = a;
    if (int'(idx) < int'(SAMPLE_W)) r[SAMPLE_W-1-int'(idx)] = b;
    return r;
  endfunction

  assign is_rj  = (fmt_i == FMT_RIGHTJ);
  assign is_i2s = (fmt_i != FMT_LEFTJ) && !is_rj;
  assign edge_w = primed_q && (wclk_i != prev_w_q);

  assign msb_acc   = put_msb(acc_q, cnt_q, sdata_i);
  assign shift_acc = {acc_q[SAMPLE_W-2:0], sdata_i};
  assign next_acc  = is_rj ? shift_acc : msb_acc;
  assign cnt_inc   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;

  // Right-justified word: move the received bits up so the MSB lands at the top.
  always_comb begin
    if (int'(cnt_q) >= int'(SAMPLE_W)) rj_fin = acc_q;
    else                               rj_fin = acc_q << (int'(SAMPLE_W) - int'(cnt_q));
  end

  // I2S closes a word with the bit that travels in the transition slot.
  assign fin_word    = is_i2s ? msb_acc : (is_rj ? rj_fin : acc_q);
  assign fin_is_left = is_i2s ? ~prev_w_q : prev_w_q;

  assign start_acc = is_i2s ? '0 : (is_rj ? SAMPLE_W'(sdata_i) : put_msb('0, '0, sdata_i));
  assign start_cnt = is_i2s ? '0 : CNT_W'(1);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      primed_q  <= 1'b0;
      started_q <= 1'b0;
      prev_w_q  <= 1'b0;
      left_ok_q <= 1'b0;
      pair_q    <= 1'b0;
      acc_q     <= '0;
      cnt_q     <= '0;
      left_q    <= '0;
      right_q   <= '0;
    end else begin
      pair_q <= 1'b0;
      if (bit_evt_i) begin
        if (!primed_q) begin
          primed_q <= 1'b1;
          prev_w_q <= wclk_i;
          acc_q    <= '0;
          cnt_q    <= '0;
        end else if (edge_w) begin
          started_q <= 1'b1;
          prev_w_q  <= wclk_i;
          if (started_q) begin
            if (fin_is_left) begin
              left_q    <= fin_word;
              left_ok_q <= 1'b1;
            end else if (left_ok_q) begin
              right_q   <= fin_word;
              pair_q    <= 1'b1;
              left_ok_q <= 1'b0;
            end
          end
          acc_q <= start_acc;
          cnt_q <= start_cnt;
        end else begin
          acc_q <= next_acc;
          cnt_q <= cnt_inc;
        end
      end
    end
  end

  assign pair_o  = pair_q;
  assign left_o  = left_q;
  assign right_o = right_q;

  AST_PAIR_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_q |-> started_q); // R1

endmodule

// File: rtl/audrx_top.sv
module audrx_top
  import audrx_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 24,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MCLK_PER_FS = 256,
  parameter int unsigned CNT_W       = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          fmt_sel_i,
  input  logic [1:0]          bclk_src_i,
  input  logic                mclk_i,
  input  logic                bclk_i,
  input  logic                wclk_i,
  input  logic                sdata_i,
  input  logic                out_ready_i,
  output logic                out_valid_o,
  output logic [SAMPLE_W-1:0] out_left_o,
  output logic [SAMPLE_W-1:0] out_right_o
);

  localparam int unsigned N_LINES = 4;

  logic [N_LINES-1:0]  lines_q;
  logic                mclk_s, bclk_s, wclk_s, sdata_s;
  logic                bit_evt, pair_evt;
  logic [SAMPLE_W-1:0] pair_left, pair_right;
  logic                valid_q;
  logic [SAMPLE_W-1:0] left_q, right_q;

  audrx_sync #(
    .WIDTH  (N_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({mclk_i, bclk_i, wclk_i, sdata_i}),
    .q_o    (lines_q)
  );

  assign {mclk_s, bclk_s, wclk_s, sdata_s} = lines_q;

  audrx_bitclk #(
    .MCLK_PER_FS (MCLK_PER_FS)
  ) u_bitclk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (bsrc_e'(bclk_src_i)),
    .mclk_lvl_i (mclk_s),
    .pin_lvl_i  (bclk_s),
    .bit_evt_o  (bit_evt)
  );

  audrx_frame #(
    .SAMPLE_W (SAMPLE_W),
    .CNT_W    (CNT_W)
  ) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fmt_i     (fmt_e'(fmt_sel_i)),
    .bit_evt_i (bit_evt),
    .wclk_i    (wclk_s),
    .sdata_i   (sdata_s),
    .pair_o    (pair_evt),
    .left_o    (pair_left),
    .right_o   (pair_right)
  );

  // One-pair output slot: a newer pair overwrites an unaccepted one.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      left_q  <= '0;
      right_q <= '0;
    end else if (pair_evt) begin
      valid_q <= 1'b1;
      left_q  <= pair_left;
      right_q <= pair_right;
    end else if (valid_q && out_ready_i) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid_o = valid_q;
  assign out_left_o  = left_q;
  assign out_right_o = right_q;

  AST_ONE_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i |=> !out_valid_o); // R9

  AST_HOLD_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o); // R10

  AST_STALL_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i && !pair_evt |=> $stable(out_left_o) && $stable(out_right_o)); // R10

endmodule

// File: tb/audrx_top_tb.sv
`timescale 1ns/1ps
module audrx_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic [1:0]  bclk_src = 2'd0;
  logic        mclk = 1'b0, bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [23:0] out_left, out_right;

  int checks = 0;
  int errors = 0;
  int got = 0;
  int first_frame = 1;
  int cur_n = 16;
  int cur_fmt = 0;
  string cur_tag = "";
  logic prev_hs = 1'b0;
  int cycles = 0;

  always #2 clk = ~clk;

  audrx_top u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .fmt_sel_i   (fmt_sel),
    .bclk_src_i  (bclk_src),
    .mclk_i      (mclk),
    .bclk_i      (bclk),
    .wclk_i      (wclk),
    .sdata_i     (sdata),
    .out_ready_i (out_ready),
    .out_valid_o (out_valid),
    .out_left_o  (out_left),
    .out_right_o (out_right)
  );

  function automatic logic [31:0] wordv(input int f, input int c, input int n);
    logic [63:0] v;
    v = (64'(f) * 64'h2545_F491) ^ (64'(c + 1) * 64'h9E37_79B9) ^ (64'(n) * 64'h0100_0193);
    if (n < 32) v = v & ((64'd1 << n) - 64'd1);
    return v[31:0];
  endfunction

  function automatic logic [23:0] exp_out(input int f, input int c, input int n, input int fmt);
    logic [31:0] raw;
    raw = wordv(f, c, n);
    if (n >= 24) return (fmt == 2) ? raw[23:0] : 24'(raw >> (n - 24));
    return 24'(raw << (24 - n));
  endfunction

  function automatic logic ljbit(input int s, input int n);
    int f, c, k;
    logic [31:0] w;
    f = s / (2 * n);
    c = (s / n) % 2;
    k = s % n;
    w = wordv(f, c, n);
    return w[n - 1 - k];
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h exp %h", cur_tag, what, act, exp);
    end
  endtask

  // Output monitor: compares every accepted pair and the one-beat rule.
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_hs = 1'b0;
    end else begin
      if (prev_hs) check(!out_valid, "R9 valid after accepted beat", 32'(out_valid), 32'd0);
      prev_hs = out_valid && out_ready;
      if (out_valid && out_ready) begin
        check(out_left == exp_out(got + first_frame, 0, cur_n, cur_fmt), "left sample",
              32'(out_left), 32'(exp_out(got + first_frame, 0, cur_n, cur_fmt)));
        check(out_right == exp_out(got + first_frame, 1, cur_n, cur_fmt), "right sample",
              32'(out_right), 32'(exp_out(got + first_frame, 1, cur_n, cur_fmt)));
        got++;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: got %0d exp below 190000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic drive_slot(input int src, input logic w, input logic d, input int div, input int idx);
    wclk  = w;
    sdata = d;
    if (src == 1) begin
      repeat (div) begin
        repeat (4) @(negedge clk);
        mclk = 1'b1;
        repeat (4) @(negedge clk);
        mclk = 1'b0;
      end
    end else if (src == 2) begin
      bclk = idx[0] ^ idx[2];
      repeat (4) @(negedge clk);
      mclk = 1'b1;
      repeat (4) @(negedge clk);
      mclk = 1'b0;
    end else begin
      repeat (4) @(negedge clk);
      bclk = 1'b1;
      repeat (4) @(negedge clk);
      bclk = 1'b0;
    end
  endtask

  task automatic run(input int fmt, input int src, input int n, input int frames,
                     input logic strap, input logic rdy, input int first, input string tag);
    logic left_lvl;
    int div;
    left_lvl = (fmt == 0) ? 1'b0 : 1'b1;
    div = 256 / (2 * n);
    @(negedge clk);
    rst_n = 1'b0;
    fmt_sel = 2'(fmt);
    bclk_src = 2'(src);
    mclk = 1'b0;
    bclk = (src == 1) ? strap : 1'b0;
    wclk = left_lvl;
    sdata = 1'b0;
    out_ready = rdy;
    repeat (4) @(negedge clk);
    got = 0;
    first_frame = first;
    cur_n = n;
    cur_fmt = fmt;
    cur_tag = tag;
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!out_valid, "R1 valid low after reset", 32'(out_valid), 32'd0);
    repeat (6) @(negedge clk);
    for (int s = 0; s <= (frames + 1) * 2 * n; s++) begin
      logic w, d;
      w = (((s / n) % 2) == 0) ? left_lvl : ~left_lvl;
      d = (fmt == 0) ? ((s == 0) ? 1'b0 : ljbit(s - 1, n)) : ljbit(s, n);
      drive_slot(src, w, d, div, s);
    end
    repeat (20) @(negedge clk);
    if (rdy) check(got == frames, "R1 pair count", 32'(got), 32'(frames));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_tag = "R1";
    check(!out_valid && out_left == 24'd0 && out_right == 24'd0, "reset outputs",
          {7'd0, out_valid, out_left}, 32'd0);
    rst_n = 1'b1;

    for (int n = 16; n <= 32; n += 8) begin
      run(0, 0, n, 3, 1'b0, 1'b1, 1, "R2 R5 R6");
      run(1, 0, n, 3, 1'b0, 1'b1, 1, "R3 R5 R6");
      run(2, 0, n, 3, 1'b0, 1'b1, 1, "R4 R5 R6");
    end

    run(0, 2, 32, 3, 1'b0, 1'b1, 1, "R2 R8");
    run(1, 1, 16, 3, 1'b1, 1'b1, 1, "R3 R7");
    run(2, 1, 32, 3, 1'b0, 1'b1, 1, "R4 R7");

    // Stall: ready held low through three completed pairs, only the newest remains.
    run(1, 0, 24, 3, 1'b0, 1'b0, 3, "R10 R11");
    check(out_valid, "R10 valid held under stall", 32'(out_valid), 32'd1);
    check(out_left == exp_out(3, 0, 24, 1), "R11 newest left kept", 32'(out_left), 32'(exp_out(3, 0, 24, 1)));
    check(out_right == exp_out(3, 1, 24, 1), "R11 newest right kept", 32'(out_right), 32'(exp_out(3, 1, 24, 1)));
    begin
      logic [23:0] held;
      held = out_left;
      repeat (5) @(negedge clk);
      check(out_left == held && out_valid, "R10 data stable under stall", 32'(out_left), 32'(held));
    end
    @(posedge clk);
    #1 out_ready = 1'b1;
    repeat (4) @(negedge clk);
    check(got == 1, "R9 single beat on release", 32'(got), 32'd1);
    check(!out_valid, "R9 valid low after release", 32'(out_valid), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule